// File: doc/BRIEF.md
# Selective-Precharge CAM Word Matcher

This block is a cycle-level model of one word of a content-addressable memory. It holds a data word and a valid flag and compares them against a search key. The comparison runs over an internal match line that moves through three phases in turn: clear, charge and evaluate.

The key bits are split into two groups at parameter `GATE_BITS`. The low `GATE_BITS` bits gate the charge: the line rises only when every one of them agrees with the key. The remaining high bits act in parallel during evaluate, and any disagreement among them pulls the line back down. With `GATE_BITS = 0` the line always charges and any mismatch discharges it. With `GATE_BITS = WIDTH` the line charges only on a full match. Either way the final answer is the same; only the number of discharge events changes.

A saturating counter records how often a charged line was discharged. This lets a user compare the switching activity of different split points.

Top module: `cam_spw_word`

## Requirements
- R1: Every search starts with a clear phase that forces the match line `ml_o` to 0; `ml_o` reads 0 in the cycle after the clear phase.
- R2: A search request accepted at clock edge k (block idle, no write in that cycle) gives clear after edge k, charge after k+1, evaluate after k+2 and the result after k+3. The block is back to idle after k+4.
- R3: After the charge phase, `ml_o` is 1 exactly when the word is valid and stored bits [GATE_BITS-1:0] equal the same key bits; otherwise it is 0.
- R4: After the evaluate phase, `ml_o` is 0 if any stored bit in [WIDTH-1:GATE_BITS] differs from the key; otherwise it keeps its charged value.
- R5: `match_o` is 1 exactly when the word is valid and all WIDTH stored bits equal the key, for every value of GATE_BITS.
- R6: While the stored valid flag is 0, `ml_o` is 0 from the next cycle on, and no search reports a match.
- R7: `match_vld_o` is high for exactly one cycle per accepted search, in the cycle after edge k+3; `match_o` holds that result until the next strobe.
- R8: A write and a search request in the same idle cycle: the write is applied at that edge, and the search starts one cycle later using the newly written word.
- R9: `dis_cnt_o` increments by one at the end of each evaluate phase that drives a charged line to 0. It stops at 2^CNT_W-1.
- R10: Search requests that arrive while a search is in progress are ignored and do not change the result under way.
- R11: After reset `ml_o`, `match_o`, `match_vld_o` and `dis_cnt_o` are 0, the stored word is invalid, and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write the stored word and flag |
| wr_data | input | WIDTH | Data to store |
| wr_valid | input | 1 | Valid flag to store |
| srch_req | input | 1 | Start a search (taken only when idle) |
| srch_key | input | WIDTH | Search key, sampled with the request |
| ml_o | output | 1 | Current match line level |
| match_o | output | 1 | Registered search result |
| match_vld_o | output | 1 | One-cycle result strobe |
| dis_cnt_o | output | CNT_W | Saturating discharge event count |

## Verification
The bench builds three copies side by side on the same stimulus. The main one splits a 16-bit word at 4 bits. A second uses a split of 0 and a 3-bit counter, so counter saturation is reached within a few searches. A third uses a split of 16, where no discharge can ever happen. Running the same keys through all three shows that the match results are identical and that the discharge counts fall as the split grows. The partial-match keys, which differ in a single gated or ungated bit, exercise both halves of the line.

// File: rtl/cam_spw_pkg.sv
package cam_spw_pkg;
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_CLEAR  = 3'd1,
    PH_CHARGE = 3'd2,
    PH_EVAL   = 3'd3,
    PH_DONE   = 3'd4
  } phase_t;
endpackage

// File: rtl/cam_spw_store.sv
module cam_spw_store #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             wr_valid,
  output logic [WIDTH-1:0] st_data,
  output logic             st_valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_data  <= '0;
      st_valid <= 1'b0;
    end else if (wr_en) begin
      st_data  <= wr_data;
      st_valid <= wr_valid;
    end
  end
endmodule

// File: rtl/cam_spw_seq.sv
module cam_spw_seq
  import cam_spw_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   srch_req,
  input  logic   wr_en,
  output phase_t phase,
  output logic   take_key
);
  logic   pend;
  logic   start;
  phase_t nxt;

  assign take_key = (phase == PH_IDLE) && srch_req && !pend;
  assign start    = (phase == PH_IDLE) && (srch_req || pend) && !wr_en;

  always_comb begin
    nxt = phase;
    unique case (phase)
      PH_IDLE:   if (start) nxt = PH_CLEAR;
      PH_CLEAR:  nxt = PH_CHARGE;
      PH_CHARGE: nxt = PH_EVAL;
      PH_EVAL:   nxt = PH_DONE;
      PH_DONE:   nxt = PH_IDLE;
      default:   nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      pend  <= 1'b0;
    end else begin
      phase <= nxt;
      if (phase == PH_IDLE && srch_req && wr_en) pend <= 1'b1;
      else if (start)                            pend <= 1'b0;
    end
  end
endmodule

// File: rtl/cam_spw_line.sv
module cam_spw_line
  import cam_spw_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  phase_t           phase,
  input  logic             st_valid,
  input  logic             gate_hit,
  input  logic             rest_hit,
  output logic             ml,
  output logic             match,
  output logic             vld,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic discharge;
  assign discharge = (phase == PH_EVAL) && ml && !(rest_hit && st_valid);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ml    <= 1'b0;
      match <= 1'b0;
      vld   <= 1'b0;
      cnt   <= '0;
    end else begin
      vld <= 1'b0;
      if (!st_valid) begin
        ml <= 1'b0;
      end else begin
        unique case (phase)
          PH_CLEAR:  ml <= 1'b0;
          PH_CHARGE: ml <= gate_hit;
          PH_EVAL:   ml <= ml && rest_hit;
          default:   ml <= ml;
        endcase
      end
      if (phase == PH_EVAL) begin
        match <= ml && rest_hit && st_valid;
        vld   <= 1'b1;
      end
      if (discharge && cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/cam_spw_word.sv
module cam_spw_word
  import cam_spw_pkg::*;
#(
  parameter int WIDTH     = 16,
  parameter int GATE_BITS = 4,
  parameter int CNT_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             wr_valid,
  input  logic             srch_req,
  input  logic [WIDTH-1:0] srch_key,
  output logic             ml_o,
  output logic             match_o,
  output logic             match_vld_o,
  output logic [CNT_W-1:0] dis_cnt_o
);
  function automatic logic [WIDTH-1:0] low_mask(input int n);
    logic [WIDTH-1:0] m;
    for (int i = 0; i < WIDTH; i++) m[i] = (i < n);
    return m;
  endfunction

  function automatic logic agree(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b,
                                 input logic [WIDTH-1:0] m);
    return ~|((a ^ b) & m);
  endfunction

  localparam logic [WIDTH-1:0] GATE_MASK = low_mask(GATE_BITS);
  localparam logic [WIDTH-1:0] REST_MASK = ~GATE_MASK;

  logic [WIDTH-1:0] st_data;
  logic             st_valid;
  logic [WIDTH-1:0] key_q;
  logic             take_key;
  phase_t           phase;
  logic             gate_hit;
  logic             rest_hit;

  cam_spw_store #(.WIDTH(WIDTH)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_valid(wr_valid), .st_data(st_data), .st_valid(st_valid)
  );

  cam_spw_seq u_seq (
    .clk(clk), .rst_n(rst_n), .srch_req(srch_req), .wr_en(wr_en),
    .phase(phase), .take_key(take_key)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        key_q <= '0;
    else if (take_key) key_q <= srch_key;
  end

  assign gate_hit = agree(st_data, key_q, GATE_MASK);
  assign rest_hit = agree(st_data, key_q, REST_MASK);

  cam_spw_line #(.CNT_W(CNT_W)) u_line (
    .clk(clk), .rst_n(rst_n), .phase(phase), .st_valid(st_valid),
    .gate_hit(gate_hit), .rest_hit(rest_hit), .ml(ml_o), .match(match_o),
    .vld(match_vld_o), .cnt(dis_cnt_o)
  );
endmodule

// File: rtl/cam_spw_chk.sv
module cam_spw_chk
  import cam_spw_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input phase_t           phase,
  input logic             ml,
  input logic             match,
  input logic             vld,
  input logic             st_valid,
  input logic             gate_hit,
  input logic             rest_hit,
  input logic [CNT_W-1:0] cnt
);
  a_r1_clear_low: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_CLEAR |=> !ml);
  a_r2_order: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_CLEAR |=> phase == PH_CHARGE);
  a_r3_charge: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_CHARGE |=> ml == $past(st_valid && gate_hit));
  a_r4_eval_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_EVAL && !rest_hit) |=> !ml);
  a_r5_result_line: assert property (@(posedge clk) disable iff (!rst_n)
    vld |-> match == ml);
  a_r6_invalid_low: assert property (@(posedge clk) disable iff (!rst_n)
    !st_valid |=> !ml);
  a_r7_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    vld |=> !vld);
  a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    &cnt |=> &cnt);
endmodule

bind cam_spw_word cam_spw_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .phase(phase), .ml(ml_o), .match(match_o),
  .vld(match_vld_o), .st_valid(st_valid), .gate_hit(gate_hit),
  .rest_hit(rest_hit), .cnt(dis_cnt_o)
);

// File: tb/cam_spw_word_test.sv
module cam_spw_word_test;
  localparam int W = 16;
  localparam int G = 4;

  logic clk = 0;
  logic rst_n = 0;
  logic wr_en = 0, wr_valid = 0, srch_req = 0;
  logic [W-1:0] wr_data = '0, srch_key = '0;
  logic ml_a, m_a, v_a, ml_b, m_b, v_b, ml_c, m_c, v_c;
  logic [7:0] c_a, c_c;
  logic [2:0] c_b;

  int total = 0, bad = 0;
  int e_a = 0, e_b = 0, e_c = 0;
  logic [W-1:0] s_data = '0;
  logic s_valid = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  cam_spw_word #(.WIDTH(W), .GATE_BITS(G), .CNT_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_valid(wr_valid),
    .srch_req(srch_req), .srch_key(srch_key), .ml_o(ml_a), .match_o(m_a),
    .match_vld_o(v_a), .dis_cnt_o(c_a));
  cam_spw_word #(.WIDTH(W), .GATE_BITS(0), .CNT_W(3)) u_nor (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_valid(wr_valid),
    .srch_req(srch_req), .srch_key(srch_key), .ml_o(ml_b), .match_o(m_b),
    .match_vld_o(v_b), .dis_cnt_o(c_b));
  cam_spw_word #(.WIDTH(W), .GATE_BITS(W), .CNT_W(8)) u_nand (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_valid(wr_valid),
    .srch_req(srch_req), .srch_key(srch_key), .ml_o(ml_c), .match_o(m_c),
    .match_vld_o(v_c), .dis_cnt_o(c_c));

  function automatic bit low_eq(logic [W-1:0] a, logic [W-1:0] b, int n);
    for (int i = 0; i < n; i++) if (a[i] != b[i]) return 0;
    return 1;
  endfunction
  function automatic bit high_eq(logic [W-1:0] a, logic [W-1:0] b, int n);
    for (int i = n; i < W; i++) if (a[i] != b[i]) return 0;
    return 1;
  endfunction
  function automatic int next_cnt(int c, int n, int mx, logic [W-1:0] d,
                                  logic v, logic [W-1:0] k);
    if (v && low_eq(d, k, n) && !high_eq(d, k, n) && c < mx) return c + 1;
    return c;
  endfunction

  task automatic check(string rq, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic write(logic [W-1:0] d, logic v);
    @(negedge clk);
    wr_en = 1; wr_data = d; wr_valid = v;
    @(negedge clk);
    wr_en = 0;
    s_data = d; s_valid = v;
  endtask

  // request at a negedge, accepted at the next posedge; optional write in same cycle
  task automatic search(logic [W-1:0] k, bit with_wr, logic [W-1:0] wd, logic wv,
                        bit busy_poke);
    logic em;
    @(negedge clk);
    srch_req = 1; srch_key = k;
    if (with_wr) begin wr_en = 1; wr_data = wd; wr_valid = wv; end
    @(negedge clk);
    srch_req = 0; wr_en = 0;
    if (with_wr) begin
      s_data = wd; s_valid = wv;
      check("R8 deferred start: no strobe yet", v_a, 0);
      @(negedge clk);
    end
    // now in clear phase
    @(negedge clk);
    check("R1 line cleared", ml_a, 0);
    if (busy_poke) begin srch_req = 1; srch_key = ~k; end
    @(negedge clk);
    srch_req = 0;
    check("R3 charge gate", ml_a, s_valid && low_eq(s_data, k, G));
    check("R3 charge nor", ml_b, s_valid);
    check("R3 charge nand", ml_c, s_valid && s_data == k);
    @(negedge clk);
    em = s_valid && (s_data == k);
    e_a = next_cnt(e_a, G, 255, s_data, s_valid, k);
    e_b = next_cnt(e_b, 0, 7, s_data, s_valid, k);
    e_c = next_cnt(e_c, W, 255, s_data, s_valid, k);
    check("R2 R7 strobe", {v_a, v_b, v_c}, 3'b111);
    check("R4 line after evaluate", ml_a, em);
    check("R5 match split4", m_a, em);
    check("R5 match nor", m_b, em);
    check("R5 match nand", m_c, em);
    if (!s_valid) check("R6 invalid no match", m_a, 0);
    check("R9 count split4", c_a, e_a);
    check("R9 count nor sat", c_b, e_b);
    check("R9 count nand", c_c, e_c);
    @(negedge clk);
    check("R7 strobe single", v_a, 0);
    check("R7 match held", m_a, em);
    if (busy_poke) begin
      @(negedge clk);
      check("R10 busy request ignored", v_a, 0);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    logic [W-1:0] d, k;
    int sel;
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    check("R11 reset ml", ml_a, 0);
    check("R11 reset match", m_a, 0);
    check("R11 reset strobe", v_a, 0);
    check("R11 reset count", c_a, 0);
    rst_n = 1;
    // R11: stored word invalid after reset, zero key must not match
    search('0, 0, '0, 0, 0);
    // directed: full match, gated-bit miss, ungated-bit miss
    write(16'hA5C3, 1);
    search(16'hA5C3, 0, '0, 0, 0);
    search(16'hA5C2, 0, '0, 0, 0);
    search(16'hA5C3 ^ 16'h0100, 0, '0, 0, 0);
    // R6: clear valid, then the line sits low and a matching key fails
    write(16'hA5C3, 0);
    @(negedge clk);
    check("R6 line low when invalid", ml_a, 0);
    search(16'hA5C3, 0, '0, 0, 0);
    // R8: write plus search in same cycle, search sees new word
    search(16'h1234, 1, 16'h1234, 1, 0);
    // R10: poke during charge
    search(16'h1234, 0, '0, 0, 1);
    // R9 saturation of the 3-bit counter via repeated ungated misses
    for (int i = 0; i < 10; i++) search(16'h1234 ^ 16'h8000, 0, '0, 0, 0);
    // constrained random
    for (int i = 0; i < 200; i++) begin
      if ($urandom_range(0, 4) == 0) write(W'($urandom), $urandom_range(0, 7) != 0);
      sel = $urandom_range(0, 9);
      if (sel < 4)      k = s_data;
      else if (sel < 7) k = s_data ^ (W'(1) << $urandom_range(0, W - 1));
      else              k = W'($urandom);
      search(k, $urandom_range(0, 9) == 0, W'($urandom), 1, $urandom_range(0, 7) == 0);
    end
    check("R9 split order nand<=split4", (e_c <= e_a), 1);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule